// File: doc/BRIEF.md
# Interleaved Reed-Solomon Link Frame Encoder

This block builds one 120-bit parallel transmit frame each time the frame strobe is high, for a serializer that follows it. Every frame begins with a 4-bit synchronisation header that marks it as a data frame or an idle frame. The rest of the frame is filled in one of two ways, selected per frame by a mode input.

In protected mode the header and 84 payload bits form 88 information bits (22 symbols of 4 bits). Two RS(15,11) codewords over GF(16) cover these bits, and their 8 parity symbols fill the low 32 bits of the frame. The two codewords take alternate symbol slots, so neighbouring symbols on the line belong to different codewords. In wide mode no parity is added: all 116 bits after the header carry payload, passed through a self-synchronising x^21+x^19+1 scrambler whose history runs on from one wide frame to the next.

Parity and scrambling are computed combinationally from the inputs present at the strobe edge. The frame register loads at that edge and holds its value until the next strobe.

Top module: `rsil_frame_encoder`

## Requirements
- R1: While reset is asserted, and after it is released until the first strobe, frame_out is all zero, and the scrambler history is all zero.
- R2: frame_out loads only at a rising clock edge where frm_stb is 1, is visible after that edge, and holds its value through every edge where frm_stb is 0, whatever the other inputs do.
- R3: frame_out[119:116] is 4'b0101 for a frame loaded with data_vld=1 and 4'b0110 for one loaded with data_vld=0, in both modes.
- R4: In protected mode (wide_mode=0), frame_out[115:32] equals payload_in[83:0] when data_vld=1 and is zero when data_vld=0. payload_in[115:84] has no effect.
- R5: Each codeword has coefficients c_0..c_14 over GF(16) with field polynomial x^4+x+1 and alpha=4'b0010. The sum of c_i·alpha^(k·i) is zero for k=1,2,3,4. c_0..c_3 are parity and c_4..c_14 are the information symbols.
- R6: Frame symbol s (s=0..29) is frame_out[4s+3:4s]. Even s belong to codeword A and odd s to codeword B. The m-th symbol of a codeword, counted upward from the least significant slot, is its coefficient c_m. So the parity sits in symbols 0..7 and the information in symbols 8..29.
- R7: In wide mode, frame_out[115:0] is y with y_i = d_i ^ y_(i-19) ^ y_(i-21). Bit 0 is earliest in time, and y bits before i=0 are taken from the previous wide frames, or are zero after reset. d is payload_in when data_vld=1 and all zero when data_vld=0.
- R8: The scrambler history changes only when a wide-mode frame is loaded. Protected-mode frames and cycles without a strobe leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encoder clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_stb | input | 1 | Frame strobe; one frame is loaded per high cycle |
| data_vld | input | 1 | 1: data frame, 0: idle frame |
| wide_mode | input | 1 | 1: scrambled wide frame, 0: protected frame |
| payload_in | input | 116 | Payload; protected mode uses bits 83:0 |
| frame_out | output | 120 | Assembled frame, bit 119 first on the line |

## Verification
Scrambling and parity generation never share a frame, but the choice between them is made per frame. So a protected frame can fall between two wide frames, and a strobe edge can coincide with a mode change. The bench interleaves modes frame by frame and keeps its own descrambler history, which advances only on wide frames. Any scrambler step taken on a protected frame or on a non-strobe cycle shows up as a descramble mismatch in the next wide frame. Protected frames are judged by recomputing all four syndromes of each de-interleaved codeword, under single-symbol sweeps and random payloads.

// File: rtl/rsil_pkg.sv
package rsil_pkg;
   localparam int unsigned GF_W = 4;
   localparam logic [GF_W:0] GF_POLY = 5'b10011;
   typedef logic [GF_W-1:0] gsym_t;
   localparam gsym_t HDR_DATA = 4'b0101;
   localparam gsym_t HDR_IDLE = 4'b0110;

   // multiply by alpha modulo the field polynomial
   function automatic gsym_t gf_xtime(gsym_t a);
      gsym_t s;
      s = {a[GF_W-2:0], 1'b0};
      return a[GF_W-1] ? (s ^ GF_POLY[GF_W-1:0]) : s;
   endfunction

   function automatic gsym_t gf_mul(gsym_t a, gsym_t b);
      gsym_t p;
      gsym_t t;
      p = '0;
      t = a;
      for (int i = 0; i < int'(GF_W); i++) begin
         if (b[i]) p = p ^ t;
         t = gf_xtime(t);
      end
      return p;
   endfunction
endpackage

// File: rtl/rsil_rs_parity.sv
module rsil_rs_parity
   import rsil_pkg::*;
#(
   parameter int unsigned K    = 11,
   parameter int unsigned NPAR = 4
) (
   input  logic [K-1:0][GF_W-1:0]    info,
   output logic [NPAR-1:0][GF_W-1:0] par
);
   localparam int unsigned NMAX = (1 << GF_W) - 1;

   typedef logic [NPAR:0][GF_W-1:0] gen_t;

   // generator with roots alpha^1 .. alpha^NPAR
   function automatic gen_t gen_poly();
      gen_t  g;
      gsym_t root;
      g    = '0;
      g[0] = gsym_t'(1);
      root = gsym_t'(1);
      for (int k = 1; k <= int'(NPAR); k++) begin
         root = gf_xtime(root);
         for (int i = int'(NPAR); i >= 1; i--) g[i] = g[i-1] ^ gf_mul(g[i], root);
         g[0] = gf_mul(g[0], root);
      end
      return g;
   endfunction

   localparam gen_t GEN = gen_poly();

   if (K + NPAR > NMAX) begin : g_len_bad
      $error("codeword longer than the field allows");
   end
   if (NPAR < 2) begin : g_par_bad
      $error("at least two parity symbols needed");
   end

   gsym_t [NPAR-1:0] rem;
   gsym_t            fb;

   // unrolled systematic divider, highest information symbol first
   always_comb begin
      rem = '0;
      fb  = '0;
      for (int j = int'(K) - 1; j >= 0; j--) begin
         fb = info[j] ^ rem[NPAR-1];
         for (int i = int'(NPAR) - 1; i >= 1; i--) rem[i] = rem[i-1] ^ gf_mul(fb, GEN[i]);
         rem[0] = gf_mul(fb, GEN[0]);
      end
   end

   assign par = rem;
endmodule

// File: rtl/rsil_scrambler.sv
module rsil_scrambler #(
   parameter int unsigned W   = 116,
   parameter int unsigned LEN = 21,
   parameter int unsigned TAP = 19
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (TAP >= LEN || TAP == 0) begin : g_tap_bad
      $error("tap must lie below the register length");
   end
   if (W < LEN) begin : g_w_bad
      $error("word narrower than scrambler history");
   end

   // ext[0] is the oldest history bit, ext[LEN+i] is output bit i
   logic [LEN-1:0]   hist;
   logic [LEN+W-1:0] ext;

   always_comb begin
      ext            = '0;
      ext[LEN-1:0]   = hist;
      for (int i = 0; i < int'(W); i++) begin
         ext[LEN+i] = din[i] ^ ext[i+LEN-TAP] ^ ext[i];
      end
   end

   assign dout = ext[LEN+W-1:LEN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   hist <= '0;
      else if (adv) hist <= ext[LEN+W-1:W];
   end
endmodule

// File: rtl/rsil_frame_encoder.sv
module rsil_frame_encoder
   import rsil_pkg::*;
#(
   parameter int unsigned FRAME_W = 120,
   parameter int unsigned ILV     = 2,
   parameter int unsigned K       = 11,
   parameter int unsigned NPAR    = 4,
   parameter bit          WIDE_EN = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          frm_stb,
   input  logic                          data_vld,
   input  logic                          wide_mode,
   input  logic [FRAME_W-GF_W-1:0]       payload_in,
   output logic [FRAME_W-1:0]            frame_out
);
   localparam int unsigned HDR_W      = GF_W;
   localparam int unsigned PAR_W      = ILV * NPAR * GF_W;
   localparam int unsigned INFO_W     = FRAME_W - PAR_W;
   localparam int unsigned FEC_PAY_W  = INFO_W - HDR_W;
   localparam int unsigned WIDE_PAY_W = FRAME_W - HDR_W;

   if (INFO_W != ILV * K * GF_W) begin : g_geom_bad
      $error("frame width does not match interleave geometry");
   end

   gsym_t                 hdr;
   logic [INFO_W-1:0]     info_bits;
   logic [PAR_W-1:0]      par_bits;
   logic [WIDE_PAY_W-1:0] wide_din;
   logic [WIDE_PAY_W-1:0] wide_bits;
   logic                  use_wide;

   assign hdr       = data_vld ? HDR_DATA : HDR_IDLE;
   assign info_bits = {hdr, (data_vld ? payload_in[FEC_PAY_W-1:0] : {FEC_PAY_W{1'b0}})};
   assign wide_din  = data_vld ? payload_in : '0;

   // codeword c takes every ILV-th symbol, starting at slot c
   for (genvar c = 0; c < int'(ILV); c++) begin : g_cw
      logic [K-1:0][GF_W-1:0]    cw_info;
      logic [NPAR-1:0][GF_W-1:0] cw_par;
      for (genvar j = 0; j < int'(K); j++) begin : g_in
         assign cw_info[j] = info_bits[GF_W*(ILV*j+c) +: GF_W];
      end
      rsil_rs_parity #(.K(K), .NPAR(NPAR)) u_par (
         .info (cw_info),
         .par  (cw_par)
      );
      for (genvar p = 0; p < int'(NPAR); p++) begin : g_out
         assign par_bits[GF_W*(ILV*p+c) +: GF_W] = cw_par[p];
      end
   end

   if (WIDE_EN) begin : g_wide
      rsil_scrambler #(.W(WIDE_PAY_W), .LEN(21), .TAP(19)) u_scr (
         .clk   (clk),
         .rst_n (rst_n),
         .adv   (frm_stb & wide_mode),
         .din   (wide_din),
         .dout  (wide_bits)
      );
      assign use_wide = wide_mode;
   end else begin : g_nowide
      assign wide_bits = wide_din;
      assign use_wide  = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       frame_out <= '0;
      else if (frm_stb) frame_out <= use_wide ? {hdr, wide_bits} : {info_bits, par_bits};
   end
endmodule

// File: rtl/rsil_frame_encoder_chk.sv
module rsil_frame_encoder_chk #(
   parameter int unsigned FRAME_W = 120,
   parameter int unsigned PAR_W   = 32,
   parameter bit          WIDE_EN = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               frm_stb,
   input logic               data_vld,
   input logic               wide_mode,
   input logic [FRAME_W-5:0] payload_in,
   input logic [FRAME_W-1:0] frame_out
);
   localparam int unsigned FPW = FRAME_W - 4 - PAR_W;

   logic fec_sel;
   assign fec_sel = !(wide_mode && WIDE_EN);

   AST_RST_CLEAR: assert property (@(posedge clk) !rst_n |=> frame_out == '0); // R1
   AST_HOLD_IDLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_stb |=> $stable(frame_out)); // R2
   AST_HDR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      frm_stb && data_vld |=> frame_out[FRAME_W-1 -: 4] == 4'b0101); // R3
   AST_HDR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      frm_stb && !data_vld |=> frame_out[FRAME_W-1 -: 4] == 4'b0110); // R3
   AST_FEC_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
      frm_stb && data_vld && fec_sel |=> frame_out[FRAME_W-5 -: FPW] == $past(payload_in[FPW-1:0])); // R4
   AST_FEC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      frm_stb && !data_vld && fec_sel |=> frame_out[FRAME_W-5 -: FPW] == '0); // R4
endmodule

bind rsil_frame_encoder rsil_frame_encoder_chk #(
   .FRAME_W (FRAME_W),
   .PAR_W   (PAR_W),
   .WIDE_EN (WIDE_EN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frm_stb    (frm_stb),
   .data_vld   (data_vld),
   .wide_mode  (wide_mode),
   .payload_in (payload_in),
   .frame_out  (frame_out)
);

// File: tb/sim_rsil_frame_encoder.sv
module sim_rsil_frame_encoder;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         frm_stb = 1'b0;
   logic         data_vld = 1'b0;
   logic         wide_mode = 1'b0;
   logic [115:0] payload_in = '0;
   logic [119:0] frame_out;

   int  n_vec  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;
   logic [20:0] sh = '0;  // bench descrambler history, sh[0] newest line bit

   always #2 clk = ~clk;

   rsil_frame_encoder u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .frm_stb    (frm_stb),
      .data_vld   (data_vld),
      .wide_mode  (wide_mode),
      .payload_in (payload_in),
      .frame_out  (frame_out)
   );

   task automatic chk(bit ok, string req, logic [119:0] act, logic [119:0] exp);
      n_vec++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] xt(logic [3:0] v);
      return v[3] ? ({v[2:0], 1'b0} ^ 4'b0011) : {v[2:0], 1'b0};
   endfunction

   function automatic logic [115:0] rnd116();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   // syndromes of codeword c (R5), read back through the R6 slot layout
   function automatic logic [15:0] syn(logic [119:0] f, int c);
      logic [15:0] s;
      s = '0;
      for (int k = 1; k <= 4; k++) begin
         logic [3:0] acc;
         acc = '0;
         for (int m = 14; m >= 0; m--) begin
            for (int t = 0; t < k; t++) acc = xt(acc);
            acc = acc ^ f[4*(2*m+c) +: 4];
         end
         s[4*(k-1) +: 4] = acc;
      end
      return s;
   endfunction

   task automatic send(bit vld, bit wide, logic [115:0] pay);
      logic [119:0] snap;
      logic [115:0] d_exp;
      logic [115:0] d_got;
      @(negedge clk);
      frm_stb    = 1'b1;
      data_vld   = vld;
      wide_mode  = wide;
      payload_in = pay;
      @(negedge clk);
      frm_stb    = 1'b0;
      snap       = frame_out;
      payload_in = rnd116();
      data_vld   = ~vld;
      wide_mode  = ~wide;
      @(negedge clk);
      chk(frame_out == snap, "R2 hold without strobe", frame_out, snap);
      chk(snap[119:116] == (vld ? 4'b0101 : 4'b0110), "R3 header", {116'd0, snap[119:116]},
          {116'd0, (vld ? 4'b0101 : 4'b0110)});
      if (!wide) begin
         logic [83:0] pe;
         pe = vld ? pay[83:0] : 84'd0;
         chk(snap[115:32] == pe, "R4 protected payload", {36'd0, snap[115:32]}, {36'd0, pe});
         chk(syn(snap, 0) == 16'd0, "R5 R6 codeword A syndromes", {104'd0, syn(snap, 0)}, 120'd0);
         chk(syn(snap, 1) == 16'd0, "R5 R6 codeword B syndromes", {104'd0, syn(snap, 1)}, 120'd0);
      end else begin
         d_exp = vld ? pay : '0;
         for (int i = 0; i < 116; i++) begin
            d_got[i] = snap[i] ^ sh[18] ^ sh[20];
            sh = {sh[19:0], snap[i]};
         end
         chk(d_got == d_exp, "R7 R8 wide descramble", {4'd0, d_got}, {4'd0, d_exp});
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(frame_out == '0, "R1 reset value", frame_out, '0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(frame_out == '0, "R1 cleared until first strobe", frame_out, '0);
      // R5 R6: every nonzero value in every single payload symbol
      for (int s = 0; s < 21; s++) begin
         for (int v = 1; v < 16; v++) begin
            logic [115:0] p;
            p = '0;
            p[4*s +: 4] = 4'(v);
            send(1'b1, 1'b0, p);
         end
      end
      send(1'b0, 1'b0, rnd116());                  // R4 idle frame
      send(1'b1, 1'b0, {32'hFFFF_FFFF, 84'd0});    // R4 upper bits ignored
      send(1'b1, 1'b0, {116{1'b1}});
      // R7: wide frames from zero history, then with carried history
      send(1'b1, 1'b1, {115'd0, 1'b1});
      send(1'b0, 1'b1, rnd116());
      for (int n = 0; n < 120; n++) send(1'b1, 1'b0, rnd116());
      for (int n = 0; n < 150; n++) send(($urandom % 4) != 0, 1'b1, rnd116());
      // R8: modes mixed frame by frame
      for (int n = 0; n < 150; n++) send(($urandom % 3) != 0, ($urandom % 2) == 1, rnd116());
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog act=running exp=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end
endmodule